// File: doc/BRIEF.md
# Parallel flash programming sequencer

This block controls the byte-wide parallel programming of a small on-chip code store. An external programmer chooses an operation with four select pins and a high-voltage-present indication. It then fires a program strobe, and it walks through the array by pulsing an increment input instead of driving an address. Inside the block sit the address counter, the self-timed byte-write and whole-array-erase sequences, the two protection lock bits, the ready/busy flag and the read path. The read path returns stored bytes, a data-polling value while a write is in flight, or fixed identification bytes.

The array is external to this block. The sequencer presents an address, write data and a write enable, and it takes read data back combinationally. A byte write merges the new data into the old byte with a bitwise AND, so programming can only clear bits. An erase walks every address and writes all ones. Write and erase durations are clock-cycle counts given as parameters.

Mode codes on `mode[3:0]`: 0000 identification read, 0011 array read, 0111 byte write, 1000 erase, 1111 set lock 1, 1100 set lock 2. Any other code does nothing.

Top module: `flash_prog_seq`

## Requirements
- R1: A rising edge on `pgm_en` clears the address counter to 0 on that clock edge. The clear wins over a simultaneous increment.
- R2: Each rising edge on `step` adds one to the address counter. Above the top address (0x7FF with 11 bits) it wraps to 0.
- R3: With `pgm_en` high, `hv_en` high, lock 1 clear and mode 0111 sampled at the clock where `prog_n` falls, the data on `din` and the current address are captured. `rdy` goes low on the clock edge that sees `prog_n` return high. It stays low for exactly WRITE_CYCLES clocks and then returns high.
- R4: While that write is in progress, reading (mode 0011) at the captured address returns bit 7 inverted and bits 6:0 as written. Once `rdy` is high again, the stored byte is returned. The array is written only while `rdy` is low.
- R5: A byte write stores the old byte ANDed with the new data, so programming never sets a bit.
- R6: With mode 1000 and `hv_en` high at the falling strobe, `rdy` goes low. If `prog_n` then stays low for ERASE_CYCLES further clocks, every byte becomes 0xFF, both locks clear, and `rdy` returns high after the sweep. A shorter low pulse changes nothing.
- R7: A strobe with `hv_en` low, or with a mode code outside the six listed, is ignored. `rdy` stays high and the array is unchanged.
- R8: A strobe with mode 1111 or 1100 and `hv_en` high sets lock 1 or lock 2 after a WRITE_CYCLES busy window. While lock 1 is set, byte writes are ignored with `rdy` high, but reads still work.
- R9: With both locks set, array reads (mode 0011) return 0xFF.
- R10: Mode 0000 returns 0x1E at address 0, 0x22 at address 1 and 0xFF elsewhere.
- R11: After reset, `rdy` is 1 and `dout` is 0xFF. `dout` is also 0xFF while `pgm_en` is low or the mode is not a read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgm_en | input | 1 | Programming enable; a rising edge clears the address |
| hv_en | input | 1 | High-voltage present; required by write, lock and erase |
| step | input | 1 | Address increment pulse |
| prog_n | input | 1 | Active-low program strobe |
| mode | input | 4 | Operation select code |
| din | input | 8 | Data to program |
| dout | output | 8 | Registered read data |
| rdy | output | 1 | High when ready, low while busy |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write enable |
| mem_rdata | input | 8 | Array read data (combinational) |

## Verification
The bench programs the first 64 addresses and counts the busy window to the exact clock, so an off-by-one timer gives a wrong `rdy` at the edge sample. It checks the polling value partway through each write, which catches a design that returns the stored byte or inverts the wrong bit. It reprograms a written byte, which exposes a design that overwrites instead of ANDing. It steps the counter across the top address to catch a missing wrap. It then drives ignored strobes (no high voltage, unknown code, lock 1 set), a too-short erase pulse, both locks set, and a full erase followed by a read of all 2048 bytes and a fresh write. This catches locks that do not block, erases that fire early, and locks that survive erase.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [3:0] {
      M_SIG   = 4'b0000,
      M_READ  = 4'b0011,
      M_WRITE = 4'b0111,
      M_ERASE = 4'b1000,
      M_LOCK2 = 4'b1100,
      M_LOCK1 = 4'b1111
   } mode_e;

   typedef enum logic [2:0] {
      S_IDLE, S_ARMED, S_BUSY, S_HOLD, S_SWEEP
   } seq_state_e;

   typedef enum logic [1:0] {
      OP_BYTE, OP_LK1, OP_LK2
   } op_e;
endpackage

// File: rtl/fps_edge.sv
`timescale 1ns/1ps
module fps_edge #(
   parameter int           N    = 1,
   parameter logic [N-1:0] INIT = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] rise
);
   logic [N-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= INIT;
      else        q <= sig;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign rise[i] = sig[i] & ~q[i];
   end
endmodule

// File: rtl/fps_addr_ctr.sv
`timescale 1ns/1ps
module fps_addr_ctr #(
   parameter int AW = 11
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   addr <= '0;
      else if (clr) addr <= '0;
      else if (inc) addr <= addr + 1'b1;
   end
endmodule

// File: rtl/fps_seq.sv
`timescale 1ns/1ps
module fps_seq
   import fps_pkg::*;
#(
   parameter int AW           = 11,
   parameter int WRITE_CYCLES = 60000,
   parameter int ERASE_CYCLES = 500000
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          hv,
   input  logic          strobe_fall,
   input  logic          strobe_rise,
   input  logic          prog_n,
   input  logic [3:0]    mode,
   input  byte_t         din,
   input  logic [AW-1:0] addr,
   input  byte_t         mem_rdata,
   output logic [AW-1:0] mem_addr,
   output byte_t         mem_wdata,
   output logic          mem_we,
   output logic          rdy,
   output logic          poll_act,
   output logic [AW-1:0] poll_addr,
   output byte_t         poll_data,
   output logic          lk1,
   output logic          lk2
);
   localparam int TMAX = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
   localparam int CW   = $clog2(TMAX + 1);

   if (WRITE_CYCLES < 1) begin : g_bad_wc
      $error("WRITE_CYCLES must be at least 1");
   end
   if (ERASE_CYCLES < 1) begin : g_bad_ec
      $error("ERASE_CYCLES must be at least 1");
   end

   seq_state_e    state;
   op_e           op;
   logic [CW-1:0] cnt;
   logic [AW-1:0] wa;
   byte_t         wd;
   logic [AW-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         op    <= OP_BYTE;
         cnt   <= '0;
         wa    <= '0;
         wd    <= '1;
         idx   <= '0;
         lk1   <= 1'b0;
         lk2   <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (en && hv && strobe_fall) begin
                  case (mode)
                     M_WRITE: if (!lk1) begin
                        state <= S_ARMED;
                        op    <= OP_BYTE;
                        wa    <= addr;
                        wd    <= din;
                     end
                     M_LOCK1: begin
                        state <= S_ARMED;
                        op    <= OP_LK1;
                     end
                     M_LOCK2: begin
                        state <= S_ARMED;
                        op    <= OP_LK2;
                     end
                     M_ERASE: begin
                        state <= S_HOLD;
                        cnt   <= '0;
                     end
                     default: ;
                  endcase
               end
            end
            S_ARMED: begin
               if (strobe_rise) begin
                  state <= S_BUSY;
                  cnt   <= CW'(WRITE_CYCLES - 1);
               end
            end
            S_BUSY: begin
               if (cnt == '0) begin
                  state <= S_IDLE;
                  if (op == OP_LK1) lk1 <= 1'b1;
                  if (op == OP_LK2) lk2 <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            S_HOLD: begin
               if (prog_n) begin
                  state <= S_IDLE;
               end else if (cnt == CW'(ERASE_CYCLES - 1)) begin
                  state <= S_SWEEP;
                  idx   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_SWEEP: begin
               idx <= idx + 1'b1;
               if (idx == '1) begin
                  state <= S_IDLE;
                  lk1   <= 1'b0;
                  lk2   <= 1'b0;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr  = addr;
      mem_wdata = mem_rdata;
      mem_we    = 1'b0;
      if (state == S_BUSY && op == OP_BYTE && cnt == '0) begin
         mem_addr  = wa;
         mem_wdata = mem_rdata & wd;
         mem_we    = 1'b1;
      end else if (state == S_SWEEP) begin
         mem_addr  = idx;
         mem_wdata = '1;
         mem_we    = 1'b1;
      end
   end

   assign rdy       = !(state == S_BUSY || state == S_HOLD || state == S_SWEEP);
   assign poll_act  = (state == S_BUSY) && (op == OP_BYTE);
   assign poll_addr = wa;
   assign poll_data = wd;
endmodule

// File: rtl/fps_rdmux.sv
`timescale 1ns/1ps
module fps_rdmux
   import fps_pkg::*;
#(
   parameter int    AW   = 11,
   parameter byte_t SIG0 = 8'h1E,
   parameter byte_t SIG1 = 8'h22
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [3:0]    mode,
   input  logic [AW-1:0] addr,
   input  byte_t         mem_rdata,
   input  logic          hold,
   input  logic          poll_act,
   input  logic [AW-1:0] poll_addr,
   input  byte_t         poll_data,
   input  logic          lk1,
   input  logic          lk2,
   output byte_t         dout
);
   byte_t nxt;

   always_comb begin
      nxt = '1;
      if (en) begin
         case (mode)
            M_READ: if (!(lk1 && lk2)) begin
               if (poll_act && poll_addr == addr)
                  nxt = {~poll_data[BYTE_W-1], poll_data[BYTE_W-2:0]};
               else
                  nxt = mem_rdata;
            end
            M_SIG: begin
               if (addr == '0)            nxt = SIG0;
               else if (addr == AW'(1))   nxt = SIG1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dout <= '1;
      else if (!hold) dout <= nxt;
   end
endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq
   import fps_pkg::*;
#(
   parameter int    ADDR_W       = 11,
   parameter int    WRITE_CYCLES = 60000,
   parameter int    ERASE_CYCLES = 500000,
   parameter byte_t SIG0         = 8'h1E,
   parameter byte_t SIG1         = 8'h22
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_en,
   input  logic              hv_en,
   input  logic              step,
   input  logic              prog_n,
   input  logic [3:0]        mode,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              rdy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   input  logic [7:0]        mem_rdata
);
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must lie in 2..16");
   end

   // edge bits: 0 enable rise, 1 step rise, 2 strobe rise, 3 strobe fall
   logic [3:0]        rise_w;
   logic [ADDR_W-1:0] addr_cnt;
   logic              poll_act_w;
   logic [ADDR_W-1:0] poll_addr_w;
   byte_t             poll_data_w;
   logic              lk1_w, lk2_w;

   fps_edge #(.N(4), .INIT(4'b0100)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  ({~prog_n, prog_n, step, pgm_en}),
      .rise (rise_w)
   );

   fps_addr_ctr #(.AW(ADDR_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (rise_w[0]),
      .inc  (rise_w[1]),
      .addr (addr_cnt)
   );

   fps_seq #(
      .AW(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (pgm_en),
      .hv         (hv_en),
      .strobe_fall(rise_w[3]),
      .strobe_rise(rise_w[2]),
      .prog_n     (prog_n),
      .mode       (mode),
      .din        (din),
      .addr       (addr_cnt),
      .mem_rdata  (mem_rdata),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_we     (mem_we),
      .rdy        (rdy),
      .poll_act   (poll_act_w),
      .poll_addr  (poll_addr_w),
      .poll_data  (poll_data_w),
      .lk1        (lk1_w),
      .lk2        (lk2_w)
   );

   fps_rdmux #(.AW(ADDR_W), .SIG0(SIG0), .SIG1(SIG1)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pgm_en),
      .mode     (mode),
      .addr     (addr_cnt),
      .mem_rdata(mem_rdata),
      .hold     (mem_we),
      .poll_act (poll_act_w),
      .poll_addr(poll_addr_w),
      .poll_data(poll_data_w),
      .lk1      (lk1_w),
      .lk2      (lk2_w),
      .dout     (dout)
   );
endmodule

// File: rtl/fps_chk.sv
`timescale 1ns/1ps
module fps_chk
   import fps_pkg::*;
#(
   parameter int    AW   = 11,
   parameter byte_t SIG0 = 8'h1E
)(
   input logic          clk,
   input logic          rst_n,
   input logic          pgm_en,
   input logic          step,
   input logic [3:0]    mode,
   input byte_t         dout,
   input logic          rdy,
   input logic          mem_we,
   input byte_t         mem_wdata,
   input byte_t         mem_rdata,
   input logic [AW-1:0] addr_cnt,
   input logic          lk1,
   input logic          lk2
);
   // R1
   addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgm_en) |=> addr_cnt == '0);

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step) && !$rose(pgm_en) |=> addr_cnt == AW'($past(addr_cnt) + 1'b1));

   // R4
   we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !rdy);

   // R5
   only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && mem_wdata != '1 |-> (mem_wdata & ~mem_rdata) == '0);

   // R8
   lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && mem_wdata != '1 |-> !lk1);

   // R9
   read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_en && lk1 && lk2 && mode == M_READ && !mem_we |=> dout == '1);

   // R10
   sig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_en && mode == M_SIG && addr_cnt == '0 && !mem_we |=> dout == SIG0);
endmodule

bind flash_prog_seq fps_chk #(.AW(ADDR_W), .SIG0(SIG0)) u_fps_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pgm_en   (pgm_en),
   .step     (step),
   .mode     (mode),
   .dout     (dout),
   .rdy      (rdy),
   .mem_we   (mem_we),
   .mem_wdata(mem_wdata),
   .mem_rdata(mem_rdata),
   .addr_cnt (addr_cnt),
   .lk1      (lk1_w),
   .lk2      (lk2_w)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;
   localparam int AW    = 11;
   localparam int DEPTH = 1 << AW;
   localparam int WC    = 20;
   localparam int EC    = 40;

   localparam logic [3:0] MD_SIG   = 4'b0000;
   localparam logic [3:0] MD_READ  = 4'b0011;
   localparam logic [3:0] MD_WRITE = 4'b0111;
   localparam logic [3:0] MD_ERASE = 4'b1000;
   localparam logic [3:0] MD_LK2   = 4'b1100;
   localparam logic [3:0] MD_LK1   = 4'b1111;
   localparam logic [3:0] MD_BAD   = 4'b0101;

   logic          clk = 1'b0;
   logic          rst_n, pgm_en, hv_en, step, prog_n;
   logic [3:0]    mode;
   logic [7:0]    din, dout, mem_wdata, mem_rdata;
   logic          rdy, mem_we;
   logic [AW-1:0] mem_addr;

   logic [7:0] mem [0:DEPTH-1];
   logic [7:0] exp_m [0:DEPTH-1];
   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
   assign mem_rdata = mem[mem_addr];

   flash_prog_seq #(
      .ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)
   ) u_flash_prog_seq (
      .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .hv_en(hv_en), .step(step),
      .prog_n(prog_n), .mode(mode), .din(din), .dout(dout), .rdy(rdy),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 29 + 7) ^ (a >> 3));
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [7:0] act, logic [7:0] e);
      n_cmp++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, e);
      end
   endtask

   task automatic pulse_step();
      step = 1'b1; tick(1);
      step = 1'b0; tick(1);
   endtask

   task automatic en_cycle();
      pgm_en = 1'b0; tick(2);
      pgm_en = 1'b1; tick(2);
   endtask

   task automatic read_chk(string tag, logic [7:0] e);
      mode = MD_READ; tick(3);
      chk(tag, dout, e);
   endtask

   task automatic strobe(logic [3:0] code, logic [7:0] d, logic h);
      mode = code; din = d; hv_en = h;
      prog_n = 1'b0; tick(2);
      prog_n = 1'b1; mode = MD_READ; tick(1);
   endtask

   task automatic prog_byte(int a, logic [7:0] d);
      strobe(MD_WRITE, d, 1'b1);
      chk("R3 busy start", {7'd0, rdy}, 8'd0);
      tick(3);
      chk("R4 polling", dout, {~d[7], d[6:0]});
      tick(WC - 4);
      chk("R3 busy last", {7'd0, rdy}, 8'd0);
      tick(1);
      chk("R3 ready again", {7'd0, rdy}, 8'd1);
      exp_m[a] = exp_m[a] & d;
      tick(2);
      chk("R5 stored", dout, exp_m[a]);
   endtask

   task automatic ignored(string tag, logic [3:0] code, logic h, logic [7:0] e);
      strobe(code, 8'h00, h);
      chk(tag, {7'd0, rdy}, 8'd1);
      tick(WC + 2);
      chk(tag, {7'd0, rdy}, 8'd1);
      chk(tag, dout, e);
   endtask

   task automatic set_lock(logic [3:0] code);
      strobe(code, 8'h00, 1'b1);
      chk("R8 lock busy", {7'd0, rdy}, 8'd0);
      tick(WC + 3);
   endtask

   task automatic erase_pulse(int n);
      mode = MD_ERASE; hv_en = 1'b1; prog_n = 1'b0; tick(2);
      chk("R6 erase busy", {7'd0, rdy}, 8'd0);
      tick(n - 2);
      prog_n = 1'b1; mode = MD_READ;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; pgm_en = 1'b0; hv_en = 1'b0; step = 1'b0;
      prog_n = 1'b1; mode = MD_READ; din = 8'h00;
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = 8'hFF; exp_m[i] = 8'hFF;
      end
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R11 reset state
      chk("R11 rdy after reset", {7'd0, rdy}, 8'd1);
      chk("R11 dout after reset", dout, 8'hFF);

      // R10 identification bytes
      mode = MD_SIG;
      en_cycle();
      tick(2);
      chk("R10 sig0", dout, 8'h1E);
      pulse_step(); tick(3);
      chk("R10 sig1", dout, 8'h22);
      pulse_step(); tick(3);
      chk("R10 sig2", dout, 8'hFF);

      // R3 R4 R5 program a block of addresses
      en_cycle();
      for (int a = 0; a < 64; a++) begin
         prog_byte(a, pat(a));
         pulse_step();
      end

      // R1 clear then read back the block
      en_cycle();
      for (int a = 0; a < 64; a++) begin
         read_chk("R1 readback", exp_m[a]);
         pulse_step();
      end

      // R5 reprogram a written byte
      en_cycle();
      prog_byte(0, 8'h3C);
      read_chk("R5 reprogram", exp_m[0]);

      // R7 ignored strobes
      ignored("R7 no hv", MD_WRITE, 1'b0, exp_m[0]);
      ignored("R7 bad code", MD_BAD, 1'b1, exp_m[0]);

      // R2 wrap at the top address
      en_cycle();
      for (int i = 0; i < DEPTH - 1; i++) pulse_step();
      prog_byte(DEPTH - 1, 8'h81);
      pulse_step();
      read_chk("R2 wrap to 0", exp_m[0]);
      pulse_step();
      read_chk("R2 after wrap", exp_m[1]);

      // R6 too-short erase has no effect
      erase_pulse(EC / 2);
      tick(3);
      chk("R6 short erase ready", {7'd0, rdy}, 8'd1);
      en_cycle();
      read_chk("R6 short erase keeps data", exp_m[0]);

      // R8 lock 1 blocks writes, reads still allowed
      set_lock(MD_LK1);
      en_cycle();
      for (int i = 0; i < 64; i++) pulse_step();
      ignored("R8 write under lock1", MD_WRITE, 1'b1, 8'hFF);
      en_cycle();
      read_chk("R8 read under lock1", exp_m[0]);

      // R9 both locks block reads
      set_lock(MD_LK2);
      en_cycle();
      read_chk("R9 read blocked", 8'hFF);
      mode = MD_SIG; tick(3);
      chk("R10 sig under locks", dout, 8'h1E);

      // R6 full erase
      erase_pulse(EC + 4);
      for (int i = 0; i < 5000 && !rdy; i++) tick(1);
      chk("R6 erase done", {7'd0, rdy}, 8'd1);
      for (int i = 0; i < DEPTH; i++) exp_m[i] = 8'hFF;
      en_cycle();
      for (int a = 0; a < DEPTH; a++) begin
         read_chk("R6 erased byte", exp_m[a]);
         pulse_step();
      end

      // R6 locks cleared by erase
      en_cycle();
      prog_byte(0, 8'h5A);
      pgm_en = 1'b0; tick(3);
      chk("R11 dout idle", dout, 8'hFF);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule